// File: doc/BRIEF.md
# Security Attribution Lookup Unit

This block decides, for every address a processor presents, whether that address is Secure, Non-secure or Non-secure-callable. Two sources feed the decision. The first is a fixed map built into the silicon, which looks only at address bit 28. Bit 28 plays no part in choosing the physical location, so each location can be reached at two addresses, and the fixed map calls one of them Secure and the other Non-secure. The second source is a programmable table of up to eight address ranges. Software fills in the table to open parts of the address space to Non-secure code.

The table can only relax the attribution. When either source calls an address Secure, the result is Secure. Out of reset the table is switched off, so the whole address space is Secure. The attribute is available combinationally in the same cycle for the access path. A strobed query port also returns a registered answer one cycle later. That answer carries the attribute, the number of the matching range and a valid flag, which is what a test-target style instruction needs to report.

A single write port programs the table. Each write names a range index, a field code and a 32-bit data word.

Top module: `sec_attr_unit`

## Requirements
- R1: An address with bit 28 set is always attributed Secure, whatever the table holds.
- R2: While the global table enable is 0, every address is attributed Secure and the region-valid flag is 0.
- R3: A range matches an address when the range is enabled, base <= addr[31:5] and addr[31:5] <= limit. The granule is 32 bytes and both the base and the limit are inclusive.
- R4: When exactly one enabled range matches and bit 28 is 0, the attribute is Non-secure-callable if that range's callable bit is 1, and Non-secure otherwise. When bit 28 is 1 the attribute is Secure, but the range is still reported.
- R5: When no enabled range matches, the attribute is Secure, the region-valid flag is 0 and the region number is 0.
- R6: When exactly one range matches and the table is enabled, the 8-bit region number equals that range's index and the region-valid flag is 1.
- R7: When two or more enabled ranges match the same address, the attribute is Secure, the region-valid flag is 0 and the region number is 0.
- R8: A query strobed in one cycle is answered in the next cycle, with rspValid high for exactly that cycle. Between answers, rspAttr, rspRegion and rspRegionValid keep their last values.
- R9: Reset clears every range enable and the global enable, so every address is Secure until the table is programmed.
- R10: The attribute encoding is 0 = Secure, 1 = Non-secure, 2 = Non-secure-callable. The value 3 never appears.
- R11: curAttr gives, in the same cycle, the attribute of qryAddr under the table contents that are current in that cycle.
- R12: Write-port field codes are as follows. 0 loads base = cfgData[31:5]. 1 loads limit = cfgData[31:5]. 2 loads enable = cfgData[0] and callable = cfgData[1]. 3 loads the global enable from cfgData[0] and ignores cfgIdx. A write takes effect for queries from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Table write strobe |
| cfgField | input | 2 | Field code of the write (R12) |
| cfgIdx | input | 3 | Range index of the write |
| cfgData | input | 32 | Write data |
| qryReq | input | 1 | Query strobe |
| qryAddr | input | 32 | Address to attribute |
| curAttr | output | 2 | Combinational attribute of qryAddr |
| rspValid | output | 1 | Query answer valid |
| rspAttr | output | 2 | Registered attribute |
| rspRegion | output | 8 | Registered matching range number |
| rspRegionValid | output | 1 | Registered region-valid flag |

## Verification
The bench aims at the inclusive edges of a range: the first and last granule, and the granule just past the limit. A design with an off-by-one compare would drop a granule at an edge or add one past it.

Aliased addresses with bit 28 set are placed inside a programmed range. A design that let the table override the fixed map would answer Non-secure there, and one that hid the match would lose the region number.

Overlapping ranges are used to catch a design that resolves an overlap by priority instead of falling back to Secure. Turning the global enable off, and querying right after reset, catches a design that keeps range results when the table is off.

// File: rtl/sau_pkg.sv
package sau_pkg;
  localparam int IDX_W = 3;          // index width for the largest table (8 ranges)
  localparam int GRAN_LSB = 5;       // 32-byte granule

  typedef enum logic [1:0] {
    ATTR_S   = 2'd0,
    ATTR_NS  = 2'd1,
    ATTR_NSC = 2'd2
  } attr_t;

  typedef struct packed {
    logic wrBase;
    logic wrLimit;
    logic wrFlags;
    logic wrGlobal;
    logic capture;
  } sau_strobe_t;
endpackage

// File: rtl/sau_ctrl.sv
module sau_ctrl
  import sau_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgField,
  input  logic        qryReq,
  output sau_strobe_t ctl,
  output logic        rspValid
);
  always_comb begin
    ctl          = '0;
    ctl.wrBase   = cfgWrEn && (cfgField == 2'd0);
    ctl.wrLimit  = cfgWrEn && (cfgField == 2'd1);
    ctl.wrFlags  = cfgWrEn && (cfgField == 2'd2);
    ctl.wrGlobal = cfgWrEn && (cfgField == 2'd3);
    ctl.capture  = qryReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= qryReq;
  end
endmodule

// File: rtl/sau_datapath.sv
module sau_datapath
  import sau_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  sau_strobe_t      ctl,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [31:0]      cfgData,
  input  logic [31:0]      qryAddr,
  input  logic             rspValid,
  output attr_t            curAttr,
  output attr_t            rspAttr,
  output logic [7:0]       rspRegion,
  output logic             rspRegionValid
);
  localparam int SLOTS = (NUM_REGIONS > 0) ? NUM_REGIONS : 1;
  localparam int GW    = 32 - GRAN_LSB;

  logic [GW-1:0]    gran;
  logic [SLOTS-1:0] hit;
  logic [SLOTS-1:0] nscVec;
  logic             gEnQ;
  logic             unusedBits;

  assign gran       = qryAddr[31:GRAN_LSB];
  assign unusedBits = ^{qryAddr[GRAN_LSB-1:0], cfgData[GRAN_LSB-1:2]};

  always_ff @(posedge clk) begin
    if (!rstN)             gEnQ <= 1'b0;
    else if (ctl.wrGlobal) gEnQ <= cfgData[0];
  end

  generate
    if (NUM_REGIONS > 0) begin : g_tbl
      for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_rgn
        logic [GW-1:0] baseQ, limitQ;
        logic          enQ, nscQ;
        always_ff @(posedge clk) begin
          if (!rstN) begin
            baseQ  <= '0;
            limitQ <= '0;
            enQ    <= 1'b0;
            nscQ   <= 1'b0;
          end else if (cfgIdx == IDX_W'(i)) begin
            if (ctl.wrBase)  baseQ  <= cfgData[31:GRAN_LSB];
            if (ctl.wrLimit) limitQ <= cfgData[31:GRAN_LSB];
            if (ctl.wrFlags) begin
              enQ  <= cfgData[0];
              nscQ <= cfgData[1];
            end
          end
        end
        assign hit[i]    = enQ && (baseQ <= gran) && (gran <= limitQ);
        assign nscVec[i] = nscQ;
      end
    end else begin : g_none
      assign hit    = '0;
      assign nscVec = '0;
    end
  endgenerate

  logic       uniqueHit;
  logic       hitNsc;
  logic [7:0] hitNum;

  always_comb begin
    hitNum = '0;
    hitNsc = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (hit[i]) begin
        hitNum = 8'(i);
        hitNsc = nscVec[i];
      end
    end
    uniqueHit = gEnQ && ($countones(hit) == 1);
    if (!uniqueHit || qryAddr[28]) curAttr = ATTR_S;
    else if (hitNsc)               curAttr = ATTR_NSC;
    else                           curAttr = ATTR_NS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspAttr        <= ATTR_S;
      rspRegion      <= '0;
      rspRegionValid <= 1'b0;
    end else if (ctl.capture) begin
      rspAttr        <= curAttr;
      rspRegion      <= uniqueHit ? hitNum : 8'd0;
      rspRegionValid <= uniqueHit;
    end
  end

  p_alias_secure_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(qryAddr[28])) |-> (rspAttr == ATTR_S));

  p_global_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !$past(gEnQ)) |-> (rspAttr == ATTR_S && !rspRegionValid));

  p_open_needs_region_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspAttr != ATTR_S) |-> rspRegionValid);

  p_region_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspRegionValid |-> (32'(rspRegion) < NUM_REGIONS));

  p_no_region_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rspRegionValid |-> (rspRegion == 8'd0));

  p_attr_legal_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspAttr != attr_t'(2'd3)));
endmodule

// File: rtl/sec_attr_unit.sv
module sec_attr_unit
  import sau_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgField,
  input  logic [2:0]  cfgIdx,
  input  logic [31:0] cfgData,
  input  logic        qryReq,
  input  logic [31:0] qryAddr,
  output logic [1:0]  curAttr,
  output logic        rspValid,
  output logic [1:0]  rspAttr,
  output logic [7:0]  rspRegion,
  output logic        rspRegionValid
);
  sau_strobe_t ctl;
  attr_t       curA, rspA;

  sau_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgField(cfgField),
    .qryReq(qryReq), .ctl(ctl), .rspValid(rspValid)
  );

  sau_datapath #(.NUM_REGIONS(NUM_REGIONS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .qryAddr(qryAddr), .rspValid(rspValid), .curAttr(curA), .rspAttr(rspA),
    .rspRegion(rspRegion), .rspRegionValid(rspRegionValid)
  );

  assign curAttr = curA;
  assign rspAttr = rspA;
endmodule

// File: tb/sim_sec_attr_unit.sv
module sim_sec_attr_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgField = '0;
  logic [2:0]  cfgIdx = '0;
  logic [31:0] cfgData = '0;
  logic        qryReq = 1'b0;
  logic [31:0] qryAddr = '0;
  logic [1:0]  curAttr, rspAttr;
  logic        rspValid, rspRegionValid;
  logic [7:0]  rspRegion;

  int nChecks = 0;
  int nFails  = 0;

  logic [26:0] mBase  [8];
  logic [26:0] mLimit [8];
  logic        mEn    [8];
  logic        mNsc   [8];
  logic        mGEn;

  sec_attr_unit u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgField(cfgField),
    .cfgIdx(cfgIdx), .cfgData(cfgData), .qryReq(qryReq), .qryAddr(qryAddr),
    .curAttr(curAttr), .rspValid(rspValid), .rspAttr(rspAttr),
    .rspRegion(rspRegion), .rspRegionValid(rspRegionValid)
  );

  always #10 clk = ~clk;

  // expected {attr[1:0], valid, region[7:0]}
  function automatic logic [10:0] expect_lookup(input logic [31:0] a);
    int         hits = 0;
    logic [7:0] num  = '0;
    logic       nsc  = 1'b0;
    logic [26:0] g   = a[31:5];
    for (int i = 0; i < 8; i++) begin
      if (mEn[i] && mBase[i] <= g && g <= mLimit[i]) begin
        hits++;
        num = 8'(i);
        nsc = mNsc[i];
      end
    end
    if (!mGEn || hits != 1) return {2'd0, 1'b0, 8'd0};
    if (a[28])              return {2'd0, 1'b1, num};
    return {(nsc ? 2'd2 : 2'd1), 1'b1, num};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] f, input int idx, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgField = f; cfgIdx = 3'(idx); cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    case (f)
      2'd0: mBase[idx]  = d[31:5];
      2'd1: mLimit[idx] = d[31:5];
      2'd2: begin mEn[idx] = d[0]; mNsc[idx] = d[1]; end
      default: mGEn = d[0];
    endcase
  endtask

  task automatic region(input int idx, input logic [26:0] b, input logic [26:0] l,
                        input logic en, input logic nsc);
    wr(2'd0, idx, {b, 5'd0});
    wr(2'd1, idx, {l, 5'd0});
    wr(2'd2, idx, {30'd0, nsc, en});
  endtask

  task automatic query(input string req, input logic [31:0] a);
    logic [10:0] e;
    @(negedge clk);
    chk({req, " R8 idle"}, 32'(rspValid), 32'd0);
    e = expect_lookup(a);
    qryReq = 1'b1; qryAddr = a;
    #1;
    chk({req, " R11 curAttr"}, 32'(curAttr), 32'(e[10:9]));
    @(negedge clk);
    qryReq = 1'b0;
    qryAddr = $urandom;
    chk({req, " R8 valid"}, 32'(rspValid), 32'd1);
    chk({req, " attr"}, 32'(rspAttr), 32'(e[10:9]));
    chk({req, " R6 valid flag"}, 32'(rspRegionValid), 32'(e[8]));
    chk({req, " R6 region"}, 32'(rspRegion), 32'(e[7:0]));
  endtask

  initial begin
    #3_000_000;
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [1:0]  heldAttr;
    logic [7:0]  heldRegion;
    logic        heldValid;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin
      mBase[i] = '0; mLimit[i] = '0; mEn[i] = 1'b0; mNsc[i] = 1'b0;
    end
    mGEn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset rspValid", 32'(rspValid), 32'd0);
    chk("R9 reset rspRegionValid", 32'(rspRegionValid), 32'd0);
    rstN = 1'b1;

    query("R9 after reset", 32'h0000_2000);
    chk("R9 secure after reset", 32'(rspAttr), 32'd0);

    // region 0: granules 0x100..0x1FF, Non-secure
    region(0, 27'h100, 27'h1FF, 1'b1, 1'b0);
    query("R2 table off", 32'h0000_2000);
    chk("R2 explicit secure", 32'(rspAttr), 32'd0);
    wr(2'd3, 5, 32'd1);
    query("R3 base edge", 32'h0000_2000);
    chk("R3 base edge NS", 32'(rspAttr), 32'd1);
    query("R3 limit edge", 32'h0000_3FFF);
    chk("R3 limit edge NS", 32'(rspAttr), 32'd1);
    query("R5 past limit", 32'h0000_4000);
    chk("R5 past limit S", 32'(rspAttr), 32'd0);
    query("R5 below base", 32'h0000_1FFF);

    // R8 outputs hold between answers
    heldAttr = rspAttr; heldRegion = rspRegion; heldValid = rspRegionValid;
    qryAddr = 32'h0000_2000;
    repeat (2) @(negedge clk);
    chk("R8 hold attr", 32'(rspAttr), 32'(heldAttr));
    chk("R8 hold region", 32'(rspRegion), 32'(heldRegion));
    chk("R8 hold valid", 32'(rspRegionValid), 32'(heldValid));

    // region 3 covers the bit-28 alias of the same granules, callable
    region(3, 27'h800100, 27'h8001FF, 1'b1, 1'b1);
    query("R1 alias secure", 32'h1000_2000);
    chk("R1 alias attr S", 32'(rspAttr), 32'd0);
    chk("R4 alias region 3", 32'(rspRegion), 32'd3);

    region(5, 27'h300, 27'h30F, 1'b1, 1'b1);
    query("R4 callable", 32'h0000_6000);
    chk("R4 callable NSC", 32'(rspAttr), 32'd2);
    chk("R10 code 2", 32'(rspRegion), 32'd5);

    region(6, 27'h1F0, 27'h20F, 1'b1, 1'b0);
    query("R7 overlap", 32'h0000_3E00);
    chk("R7 overlap S", 32'(rspAttr), 32'd0);
    chk("R7 overlap invalid", 32'(rspRegionValid), 32'd0);
    query("R7 single after overlap", 32'h0000_4000);

    wr(2'd2, 0, 32'd0);
    query("R3 disabled range", 32'h0000_2000);
    wr(2'd3, 0, 32'd0);
    query("R2 global off", 32'h0000_6000);
    chk("R2 global off S", 32'(rspAttr), 32'd0);

    // constrained random tables and addresses
    for (int t = 0; t < 20; t++) begin
      for (int i = 0; i < 8; i++) begin
        logic [26:0] b;
        b = 27'($urandom & 32'h1FFF) | (27'($urandom & 1) << 23);
        region(i, b, b + 27'($urandom & 32'h3FF), 1'($urandom), 1'($urandom));
      end
      wr(2'd3, 0, 32'($urandom % 8 != 0));
      for (int q = 0; q < 20; q++) begin
        logic [26:0] g;
        g = 27'($urandom & 32'h1FFF) | (27'($urandom & 1) << 23);
        query("R12 random", {g, 5'($urandom)});
      end
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule